// File: doc/BRIEF.md
# SMM Memory Window Decoder with Lock

This block sits on the chipset side of the memory path. It decides where each memory access goes: to DRAM, to the legacy video/PCI path, or to a dead-space responder. The decision depends on the access address and on whether the requester is in system management mode (SMM). Two 8-bit configuration registers set up the decode. The first is a control register holding the open, global-enable and lock bits. The second is an extended register holding the high-window enable, the top-segment enable and the top-segment size.

Three regions get special treatment:
- A 128 KB legacy window at 0xA0000.
- A 128 KB high alias window at 0xFEDA0000, which maps to the same DRAM.
- A top segment of selectable size, ending at the top of low memory.

SMM and non-SMM requesters see these regions differently. Once the lock bit is set, the window settings are frozen until reset. Routing is purely combinational from the registered configuration and the access inputs. A configuration write takes effect on the clock edge that samples it.

Top module: `smm_window_decoder`

## Requirements
- R1: After reset both registers read as 0x00 and the lock is clear. A non-SMM or SMM access at 0xA0000 therefore routes to PCI, and address TOLM-1 routes to DRAM. Route codes: 0 = DRAM, 1 = PCI/legacy path, 2 = dead space.
- R2: An address outside all three regions routes to DRAM when it is below TOLM and to PCI when it is at or above TOLM (default TOLM = 0x80000000).
- R3: A non-SMM access in the low window [0xA0000, 0xC0000) routes to DRAM only when open (control bit 6) is 1 and high-enable (extended bit 7) is 0. Otherwise it routes to PCI.
- R4: A non-SMM access in the high window [0xFEDA0000, 0xFEDC0000) routes to DRAM only when open is 1 and high-enable is 1. Otherwise it routes to PCI.
- R5: For an SMM access with global enable (control bit 3) set:
  - the low window routes to DRAM when high-enable is 0;
  - the high window routes to DRAM when high-enable is 1.
  Any window not claimed this way follows the non-SMM rule. With global enable clear, SMM follows the non-SMM rule.
- R6: The top segment is active when extended bit 0 is 1. Its size comes from extended bits [2:1]: 00 = 1 MB, 01 = 2 MB, 10 = 8 MB. The code 11, or a clear enable bit, means size 0. The segment covers [TOLM-size, TOLM).
- R7: Inside an active top segment, SMM accesses route to DRAM and non-SMM accesses route to dead space.
- R8: Read data is 0xFFFFFFFF for a read routed to dead space and 0 in every other case, including writes to dead space.
- R9: Writing control bit 4 (lock) as 1 sets the lock and clears open on the same edge. While the lock is set, writes to either register have no effect, including writes of 0 to the lock.
- R10: A configuration write takes effect at the clock edge that samples it. Register select 0 addresses the control register (writable bits 6, 4, 3) and select 1 the extended register (writable bits 7, 2:1, 0).
- R11: Only reset clears the lock. After reset the registers accept writes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 control, 1 extended |
| cfg_wdata | input | 8 | Configuration write data |
| acc_addr | input | 32 | Memory access address |
| acc_wr | input | 1 | Access is a write |
| acc_smm | input | 1 | Requester is in SMM |
| route | output | 2 | Route select: 0 DRAM, 1 PCI, 2 dead space |
| rd_data | output | 32 | Dead-space read data |

## Verification
Route and read data are combinational from the access inputs, so they settle in the same cycle as the address. The bench drives accesses at the falling edge and samples one time unit later. A configuration write lands on the rising edge that samples the strobe. The bench therefore checks once before that edge that the route has not yet changed, and again after it. Reset release passes through a two-stage synchronizer, and the bench waits out those cycles before its first write.

// File: rtl/smm_dec_pkg.sv
package smm_dec_pkg;
  typedef enum logic [1:0] {
    RT_DRAM = 2'd0,
    RT_PCI  = 2'd1,
    RT_DEAD = 2'd2
  } route_e;

  // control register bit positions
  localparam int CTL_GEN_B  = 3;
  localparam int CTL_LOCK_B = 4;
  localparam int CTL_OPEN_B = 6;
  // extended register bit positions
  localparam int EXT_SEG_B  = 0;
  localparam int EXT_SZ_LO  = 1;
  localparam int EXT_SZ_HI  = 2;
  localparam int EXT_HEN_B  = 7;

  localparam logic [7:0] CTL_RST_VAL  = 8'h00;
  localparam logic [7:0] EXT_RST_VAL  = 8'h00;
  localparam logic [7:0] CTL_WMASK    = 8'h58;
  localparam logic [7:0] EXT_WMASK    = 8'h87;
  localparam logic [7:0] CTL_WMASK_LK = 8'h00;
  localparam logic [7:0] EXT_WMASK_LK = 8'h00;
endpackage

// File: rtl/smm_cfg_regs.sv
module smm_cfg_regs
  import smm_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] ctl_q,
  output logic [7:0] ext_q
);
  logic       locked;
  logic [7:0] ctl_mask, ext_mask;
  logic [7:0] ctl_d, ext_d;
  logic       ctl_en, ext_en;

  assign locked = ctl_q[CTL_LOCK_B];

  always_comb begin
    ctl_mask = locked ? CTL_WMASK_LK : CTL_WMASK;
    ext_mask = locked ? EXT_WMASK_LK : EXT_WMASK;
    ctl_en   = wr_en && !wr_sel;
    ext_en   = wr_en && wr_sel;
    ctl_d    = (ctl_q & ~ctl_mask) | (wr_data & ctl_mask);
    // lock is set-only
    ctl_d[CTL_LOCK_B] = ctl_d[CTL_LOCK_B] | locked;
    if (ctl_d[CTL_LOCK_B]) ctl_d[CTL_OPEN_B] = 1'b0;
    ext_d    = (ext_q & ~ext_mask) | (wr_data & ext_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= CTL_RST_VAL;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ext_q <= EXT_RST_VAL;
    else if (ext_en) ext_q <= ext_d;
  end
endmodule

// File: rtl/smm_win_decode.sv
module smm_win_decode
  import smm_dec_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] TOLM      = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] LOW_BASE  = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFEDA_0000,
  parameter logic [ADDR_W-1:0] WIN_BYTES = 32'h0002_0000
)(
  input  logic [ADDR_W-1:0] addr,
  input  logic              smm,
  input  logic [7:0]        ctl,
  input  logic [7:0]        ext,
  output route_e            route
);
  localparam logic [ADDR_W-1:0] LOW_END  = LOW_BASE + WIN_BYTES;
  localparam logic [ADDR_W-1:0] HIGH_END = HIGH_BASE + WIN_BYTES;
  localparam logic [ADDR_W-1:0] SZ_1M    = ADDR_W'(64'h0010_0000);
  localparam logic [ADDR_W-1:0] SZ_2M    = ADDR_W'(64'h0020_0000);
  localparam logic [ADDR_W-1:0] SZ_8M    = ADDR_W'(64'h0080_0000);

  logic              open_b, gen_b, hen_b;
  logic              low_hit, high_hit, seg_hit;
  logic              low_dram, high_dram;
  logic [ADDR_W-1:0] seg_bytes, seg_base;

  assign open_b = ctl[CTL_OPEN_B];
  assign gen_b  = ctl[CTL_GEN_B];
  assign hen_b  = ext[EXT_HEN_B];

  always_comb begin
    if (!ext[EXT_SEG_B]) seg_bytes = '0;
    else begin
      case (ext[EXT_SZ_HI:EXT_SZ_LO])
        2'b00:   seg_bytes = SZ_1M;
        2'b01:   seg_bytes = SZ_2M;
        2'b10:   seg_bytes = SZ_8M;
        default: seg_bytes = '0;
      endcase
    end
    seg_base = TOLM - seg_bytes;
  end

  assign low_hit  = (addr >= LOW_BASE)  && (addr < LOW_END);
  assign high_hit = (addr >= HIGH_BASE) && (addr < HIGH_END);
  assign seg_hit  = (seg_bytes != '0) && (addr >= seg_base) && (addr < TOLM);

  // SMM claim first, then fall through to the non-SMM view
  assign low_dram  = (smm && gen_b && !hen_b) || (open_b && !hen_b);
  assign high_dram = (smm && gen_b && hen_b)  || (open_b && hen_b);

  always_comb begin
    if (seg_hit)       route = smm ? RT_DRAM : RT_DEAD;
    else if (low_hit)  route = low_dram ? RT_DRAM : RT_PCI;
    else if (high_hit) route = high_dram ? RT_DRAM : RT_PCI;
    else if (addr < TOLM) route = RT_DRAM;
    else               route = RT_PCI;
  end
endmodule

// File: rtl/smm_dead_resp.sv
module smm_dead_resp
  import smm_dec_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  route_e            route,
  input  logic              is_wr,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    if (route == RT_DEAD && !is_wr) rdata = '1;
    else                            rdata = '0;
  end
endmodule

// File: rtl/smm_window_decoder.sv
module smm_window_decoder
  import smm_dec_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] TOLM      = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] LOW_BASE  = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFEDA_0000,
  parameter logic [ADDR_W-1:0] WIN_BYTES = 32'h0002_0000
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [7:0]        cfg_wdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wr,
  input  logic              acc_smm,
  output logic [1:0]        route,
  output logic [DATA_W-1:0] rd_data
);
  logic [1:0] rst_sync_q;
  logic       rst_ns;
  logic [7:0] ctl_q, ext_q;
  route_e     route_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  smm_cfg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_ns),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .ctl_q   (ctl_q),
    .ext_q   (ext_q)
  );

  smm_win_decode #(
    .ADDR_W    (ADDR_W),
    .TOLM      (TOLM),
    .LOW_BASE  (LOW_BASE),
    .HIGH_BASE (HIGH_BASE),
    .WIN_BYTES (WIN_BYTES)
  ) u_dec (
    .addr  (acc_addr),
    .smm   (acc_smm),
    .ctl   (ctl_q),
    .ext   (ext_q),
    .route (route_w)
  );

  smm_dead_resp #(.DATA_W(DATA_W)) u_dead (
    .route (route_w),
    .is_wr (acc_wr),
    .rdata (rd_data)
  );

  assign route = route_w;
endmodule

// File: rtl/smm_window_decoder_chk.sv
module smm_window_decoder_chk
  import smm_dec_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] LOW_BASE  = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_BYTES = 32'h0002_0000
)(
  input logic              clk,
  input logic              rst_ns,
  input logic              cfg_we,
  input logic              cfg_sel,
  input logic [7:0]        cfg_wdata,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_wr,
  input logic              acc_smm,
  input logic [1:0]        route,
  input logic [DATA_W-1:0] rd_data,
  input logic [7:0]        ctl_q,
  input logic [7:0]        ext_q
);
  logic in_low;
  assign in_low = (acc_addr >= LOW_BASE) && (acc_addr < LOW_BASE + WIN_BYTES);

  // R8
  dead_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (route == 2'd2 && !acc_wr) |-> (rd_data == '1));

  // R7
  dead_only_nonsmm_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (route == 2'd2) |-> !acc_smm);

  // R3
  closed_low_no_dram_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!acc_smm && in_low && !ctl_q[CTL_OPEN_B]) |-> (route != 2'd0));

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ctl_q[CTL_LOCK_B] |=> ctl_q[CTL_LOCK_B]);

  // R9
  locked_closed_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ctl_q[CTL_LOCK_B] |-> !ctl_q[CTL_OPEN_B]);

  // R9
  locked_frozen_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ctl_q[CTL_LOCK_B] |=> ($stable(ctl_q) && $stable(ext_q)));

  // R10
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (cfg_we && !cfg_sel && !ctl_q[CTL_LOCK_B]) |=>
      (ctl_q[CTL_GEN_B] == $past(cfg_wdata[CTL_GEN_B])));
endmodule

bind smm_window_decoder smm_window_decoder_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .LOW_BASE  (LOW_BASE),
  .WIN_BYTES (WIN_BYTES)
) u_chk (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .cfg_wdata (cfg_wdata),
  .acc_addr  (acc_addr),
  .acc_wr    (acc_wr),
  .acc_smm   (acc_smm),
  .route     (route),
  .rd_data   (rd_data),
  .ctl_q     (ctl_q),
  .ext_q     (ext_q)
);

// File: tb/tb_smm_window_decoder.sv
module tb_smm_window_decoder;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic        cfg_sel;
  logic [7:0]  cfg_wdata;
  logic [31:0] acc_addr;
  logic        acc_wr;
  logic        acc_smm;
  logic [1:0]  route;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  smm_window_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .acc_wr(acc_wr),
    .acc_smm(acc_smm), .route(route), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // vector: req(8) ctl(8) ext(8) smm(1) addr(32) exp_route(2)
  localparam int NV = 23;
  localparam logic [58:0] VEC [NV] = '{
    {8'd3,  8'h00, 8'h00, 1'b0, 32'h000A_0000, 2'd1}, // R3 closed
    {8'd3,  8'h40, 8'h00, 1'b0, 32'h000A_0000, 2'd0}, // R3 open
    {8'd3,  8'h40, 8'h80, 1'b0, 32'h000B_FFFF, 2'd1}, // R3 open+high
    {8'd4,  8'h40, 8'h80, 1'b0, 32'hFEDA_0000, 2'd0}, // R4 open+high
    {8'd4,  8'h40, 8'h00, 1'b0, 32'hFEDB_FFFF, 2'd1}, // R4 high off
    {8'd4,  8'h00, 8'h80, 1'b0, 32'hFEDA_0000, 2'd1}, // R4 closed
    {8'd4,  8'h40, 8'h80, 1'b0, 32'hFEDC_0000, 2'd1}, // R4 past end
    {8'd4,  8'h40, 8'h80, 1'b0, 32'hFED9_FFFF, 2'd1}, // R4 below base
    {8'd5,  8'h08, 8'h00, 1'b1, 32'h000B_FFFF, 2'd0}, // R5 low
    {8'd5,  8'h08, 8'h80, 1'b1, 32'h000A_0000, 2'd1}, // R5 low hidden
    {8'd5,  8'h08, 8'h80, 1'b1, 32'hFEDA_1000, 2'd0}, // R5 high
    {8'd5,  8'h00, 8'h00, 1'b1, 32'h000A_0000, 2'd1}, // R5 gen off
    {8'd5,  8'h08, 8'h00, 1'b0, 32'h000A_0000, 2'd1}, // R5 non-SMM ignores gen
    {8'd2,  8'h00, 8'h00, 1'b0, 32'h0010_0000, 2'd0}, // R2 low mem
    {8'd2,  8'h00, 8'h00, 1'b0, 32'h8000_0000, 2'd1}, // R2 above TOLM
    {8'd6,  8'h00, 8'h01, 1'b0, 32'h7FF0_0000, 2'd2}, // R6 1MB base
    {8'd6,  8'h00, 8'h01, 1'b0, 32'h7FEF_FFFF, 2'd0}, // R6 1MB below
    {8'd6,  8'h00, 8'h03, 1'b0, 32'h7FE0_0000, 2'd2}, // R6 2MB base
    {8'd6,  8'h00, 8'h05, 1'b0, 32'h7F80_0000, 2'd2}, // R6 8MB base
    {8'd6,  8'h00, 8'h05, 1'b0, 32'h7F7F_FFFF, 2'd0}, // R6 8MB below
    {8'd6,  8'h00, 8'h07, 1'b0, 32'h7FFF_FFFF, 2'd0}, // R6 reserved size
    {8'd6,  8'h00, 8'h04, 1'b0, 32'h7FFF_FFFF, 2'd0}, // R6 disabled
    {8'd7,  8'h00, 8'h01, 1'b1, 32'h7FFF_FFFF, 2'd0}  // R7 SMM sees DRAM
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic smm, input logic wr, input logic [31:0] a);
    acc_smm = smm; acc_wr = wr; acc_addr = a;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    acc_addr = 0; acc_wr = 0; acc_smm = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    access(1'b0, 1'b0, 32'h000A_0000);
    chk("R1 nonsmm low", {30'd0, route}, 32'd1);
    access(1'b1, 1'b0, 32'h000A_0000);
    chk("R1 smm low", {30'd0, route}, 32'd1);
    access(1'b0, 1'b0, 32'h7FFF_FFFF);
    chk("R1 seg off", {30'd0, route}, 32'd0);
    chk("R1 rdata", rd_data, 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [58:0] v;
      logic [31:0] exp_rd;
      v = VEC[i];
      cfg_write(1'b0, v[50:43]);
      cfg_write(1'b1, v[42:35]);
      access(v[34], 1'b0, v[33:2]);
      exp_rd = (v[1:0] == 2'd2) ? 32'hFFFF_FFFF : 32'd0;
      checks++;
      if (route !== v[1:0] || rd_data !== exp_rd) begin
        errors++;
        $display("FAIL R%0d vec %0d: actual route %0d rd %h expected route %0d rd %h",
                 v[58:51], i, route, rd_data, v[1:0], exp_rd);
      end
    end

    // R8 dead-space write returns no data, read returns ones
    cfg_write(1'b0, 8'h00);
    cfg_write(1'b1, 8'h01);
    access(1'b0, 1'b1, 32'h7FF8_0000);
    chk("R8 dead write route", {30'd0, route}, 32'd2);
    chk("R8 dead write rdata", rd_data, 32'd0);
    access(1'b0, 1'b0, 32'h7FF8_0000);
    chk("R8 dead read rdata", rd_data, 32'hFFFF_FFFF);

    // R10 write lands at the sampling edge, not before
    cfg_write(1'b1, 8'h00);
    access(1'b0, 1'b0, 32'h000A_0000);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 8'h40;
    #1;
    chk("R10 before edge", {30'd0, route}, 32'd1);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk("R10 after edge", {30'd0, route}, 32'd0);

    // R9 lock
    cfg_write(1'b0, 8'h48);   // open + gen
    cfg_write(1'b0, 8'h58);   // lock with open requested
    access(1'b0, 1'b0, 32'h000A_0000);
    chk("R9 open cleared", {30'd0, route}, 32'd1);
    access(1'b1, 1'b0, 32'h000A_0000);
    chk("R9 gen kept", {30'd0, route}, 32'd0);
    cfg_write(1'b0, 8'h00);   // try to clear lock and gen
    access(1'b1, 1'b0, 32'h000A_0000);
    chk("R9 ctl write ignored", {30'd0, route}, 32'd0);
    cfg_write(1'b0, 8'h40);   // try to reopen
    access(1'b0, 1'b0, 32'h000A_0000);
    chk("R9 reopen ignored", {30'd0, route}, 32'd1);
    cfg_write(1'b1, 8'h81);   // try high enable + segment
    access(1'b0, 1'b0, 32'h7FFF_FFFF);
    chk("R9 ext write ignored seg", {30'd0, route}, 32'd0);
    access(1'b1, 1'b0, 32'h000A_0000);
    chk("R9 ext write ignored hen", {30'd0, route}, 32'd0);

    // R11 reset clears lock
    do_reset();
    access(1'b1, 1'b0, 32'h000A_0000);
    chk("R11 gen cleared", {30'd0, route}, 32'd1);
    cfg_write(1'b0, 8'h40);
    access(1'b0, 1'b0, 32'h000A_0000);
    chk("R11 writable again", {30'd0, route}, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule